// File: doc/BRIEF.md
# Hash Block Collector and Chaining-State Controller

This block is the front end of a combined MD5/SHA-1 hash engine. A DMA-style master writes message data into a fixed address window in whole 32-bit words. The block gathers exactly one 64-byte message block, hands it to an external compression core together with the current 160-bit chaining state, and waits for the core to answer. The answer becomes the new chaining state, and a processed-byte counter grows by 64. A completion flag is then raised for software. The round functions, padding and length encoding live elsewhere.

At enable, the chaining state comes either from the algorithm's standard initial vector or from a 28-byte context that software wrote into a context-in window beforehand. For each block, software decides before the last write whether the 28-byte result window will show a final digest or a resumable state image. The window holds only one of these at a time. A resumable image can later be written back into the context-in window to carry on the same hash.

Each write is a transaction: a start cycle carries the address and byte length, and the data words follow. The block checks every transaction before it accepts any of its words.

The controller has four states. `ST_OFF` is disabled. `ST_FILL` collects bytes. `ST_LAUNCH` presents the start pulse for one cycle. `ST_WAIT` waits for the core. The transitions are:
- `ST_OFF` → `ST_FILL` on a rising enable; this loads the state and counter.
- `ST_FILL` → `ST_OFF` when enable is low.
- `ST_FILL` → `ST_LAUNCH` when the 64th byte is accepted.
- `ST_LAUNCH` → `ST_WAIT` unconditionally.
- `ST_WAIT` → `ST_FILL` on core done.

Top module: `hash_block_front`

## Requirements
- R1: After reset, `busy`, `irq`, `err` and `core_start` are 0, and every word of the result window reads 0.
- R2: A rising `enable` with `resume` = 0 loads the standard initial vector, as little-endian 32-bit words with word k at bits 32k+31:32k of `core_state_in`:
  - word 0 = 67452301h, word 1 = EFCDAB89h, word 2 = 98BADCFEh, word 3 = 10325476h;
  - word 4 = C3D2E1F0h when `mode_sha1` = 1, and 0 for MD5.
  - The byte counter becomes 0.
- R3: A rising `enable` with `resume` = 1 loads the chaining state from context-in words 0..4 and the 64-bit counter from words 5 (low) and 6 (high). Context-in word k is written at window offset 40h+4k.
- R4: `core_start` is a one-cycle pulse. It is high in the cycle after the edge that accepts the word completing 64 bytes, and never earlier. A block may arrive in several transactions.
- R5: `core_block` carries byte n of the window, offsets 00h..3Fh, at bits 8n+7:8n. The data word written at offset a supplies byte a from bits 7:0 up to byte a+3 from bits 31:24.
- R6: When `core_done` arrives while waiting, `irq` is set. It stays set until `irq_clr`.
- R7: The result window is read at offsets 70h..8Bh, with word k at 70h+4k. Its content depends on `last_blk`, sampled with the word that completes the block:
  - `last_blk` = 0: words 0..4 are the new state and words 5..6 are the counter (low word first).
  - `last_blk` = 1: words 0..4 are the digest and words 5..6 read 0.
- R8: A transaction is rejected as a whole, and `err` is set until the next rising `enable`, when any of these holds:
  - its length is 0 or not a multiple of 4;
  - its address is not word aligned;
  - it falls outside the block or context-in window;
  - it would take the collected byte total past 64.
- R9: `busy` is high from the start pulse until the core answers. A block-buffer write started while busy is rejected with `err`. It changes neither the buffer nor the byte total.
- R10: Each later block of the same hash is started with the state returned for the previous block.
- R11: `core_sha1` follows `mode_sha1` as latched at enable. In MD5 mode, state word 4 is forced to 0 both toward the core and in the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Engine enable; a rising edge starts a hash |
| mode_sha1 | input | 1 | 1 = SHA-1, 0 = MD5; sampled at enable |
| resume | input | 1 | 1 = continue from the context-in window at enable |
| last_blk | input | 1 | Selects digest (1) or resume image (0) for the current block |
| irq_clr | input | 1 | Clears the completion flag |
| wr_start | input | 1 | Transaction start strobe |
| wr_addr | input | 16 | Transaction byte address |
| wr_len | input | 7 | Transaction byte length |
| wr_valid | input | 1 | Data word strobe |
| wr_data | input | 32 | Data word |
| rd_addr | input | 16 | Result-window read address |
| rd_data | output | 32 | Result-window read word |
| busy | output | 1 | Compression in progress |
| irq | output | 1 | Block completion flag |
| err | output | 1 | Sticky rejected-transaction flag |
| core_start | output | 1 | Start pulse to the compression core |
| core_sha1 | output | 1 | Algorithm select to the core |
| core_block | output | 512 | Message block to the core |
| core_state_in | output | 160 | Chaining state to the core |
| core_done | input | 1 | Done pulse from the core |
| core_state_out | input | 160 | New chaining state from the core |

## Verification
The first SHA-1 block arrives as two transactions of unequal size. A following block arrives as sixteen single-word writes in descending address order. Together these show whether the start pulse is tied to the byte total rather than to the transaction count, and whether each word lands by its address rather than by arrival order. Rejected patterns are covered with several cases:
- a length that is not a multiple of 4;
- a transaction that overruns 64 bytes;
- a write during compression.

Each of these is followed by valid data, so that a wrongly counted byte would move or suppress the start pulse. A resumed MD5 hash from a written context, compared with a fresh SHA-1 hash, separates the two state sources, the algorithm masking, and the counter carried across the context.

// File: rtl/hbf_pkg.sv
package hbf_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_FILL,
        ST_LAUNCH,
        ST_WAIT
    } hbf_state_e;

    localparam int WORD_BITS = 32;
    localparam int ST_WORDS  = 5;
    localparam int CTX_WORDS = 7;

    function automatic logic [ST_WORDS*WORD_BITS-1:0] hbf_iv(input logic sha1);
        logic [ST_WORDS*WORD_BITS-1:0] v;
        v[31:0]    = 32'h6745_2301;
        v[63:32]   = 32'hEFCD_AB89;
        v[95:64]   = 32'h98BA_DCFE;
        v[127:96]  = 32'h1032_5476;
        v[159:128] = sha1 ? 32'hC3D2_E1F0 : 32'h0;
        return v;
    endfunction

    function automatic logic [ST_WORDS*WORD_BITS-1:0] hbf_mask(
        input logic sha1, input logic [ST_WORDS*WORD_BITS-1:0] s);
        logic [ST_WORDS*WORD_BITS-1:0] v;
        v = s;
        if (!sha1) v[159:128] = 32'h0;
        return v;
    endfunction

endpackage

// File: rtl/hbf_word_store.sv
module hbf_word_store #(
    parameter int WORDS = 16,
    parameter int IW    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [IW-1:0]         idx,
    input  logic [31:0]           data,
    output logic [WORDS*32-1:0]   flat
);

    for (genvar k = 0; k < WORDS; k++) begin : g_word
        logic [31:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '0;
            else if (we && idx == IW'(k))
                word_q <= data;
        end
        assign flat[k*32 +: 32] = word_q;
    end

endmodule

// File: rtl/hbf_wr_decode.sv
module hbf_wr_decode #(
    parameter logic [15:0] BASE      = 16'h7A00,
    parameter int          BLK_BYTES = 64,
    parameter int          CTX_OFF   = 'h40,
    parameter int          CTX_BYTES = 28,
    parameter int          IW        = 5,
    parameter int          FW        = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_start,
    input  logic [15:0]   wr_addr,
    input  logic [6:0]    wr_len,
    input  logic          wr_valid,
    input  logic          buf_allow,
    input  logic          ctx_allow,
    input  logic [FW-1:0] fill_cnt,
    output logic          buf_we,
    output logic          ctx_we,
    output logic [IW-1:0] word_idx,
    output logic          reject
);

    localparam logic [16:0] BLK_END = 17'(BLK_BYTES);
    localparam logic [16:0] CTX_LO  = 17'(CTX_OFF);
    localparam logic [16:0] CTX_END = 17'(CTX_OFF + CTX_BYTES);

    logic [15:0]   off;
    logic [16:0]   end_b;
    logic [16:0]   fill_end;
    logic          len_ok, buf_hit, ctx_hit;
    logic          act_q, to_ctx_q;
    logic [IW-1:0] ptr_q;
    logic [4:0]    left_q;
    logic          fire;

    always_comb begin
        off      = wr_addr - BASE;
        end_b    = {1'b0, off} + 17'(wr_len);
        fill_end = 17'(fill_cnt) + 17'(wr_len);
        len_ok   = (wr_len != 7'd0) && (wr_len[1:0] == 2'b00) && (off[1:0] == 2'b00);
        buf_hit  = buf_allow && len_ok && (end_b <= BLK_END) && (fill_end <= BLK_END);
        ctx_hit  = ctx_allow && len_ok && ({1'b0, off} >= CTX_LO) && (end_b <= CTX_END);
        reject   = wr_start && !buf_hit && !ctx_hit;
        fire     = act_q && wr_valid && !wr_start;
        buf_we   = fire && !to_ctx_q;
        ctx_we   = fire && to_ctx_q;
        word_idx = ptr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q    <= 1'b0;
            to_ctx_q <= 1'b0;
            ptr_q    <= '0;
            left_q   <= '0;
        end else if (wr_start) begin
            act_q    <= buf_hit || ctx_hit;
            to_ctx_q <= ctx_hit;
            ptr_q    <= buf_hit ? IW'(off[15:2]) : IW'((off - 16'(CTX_OFF)) >> 2);
            left_q   <= wr_len[6:2];
        end else if (fire) begin
            ptr_q  <= ptr_q + 1'b1;
            left_q <= left_q - 1'b1;
            act_q  <= (left_q != 5'd1);
        end
    end

endmodule

// File: rtl/hash_block_front.sv
module hash_block_front
    import hbf_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h7A00,
    parameter int          BLK_BYTES = 64,
    parameter int          CTX_OFF   = 'h40,
    parameter int          OUT_OFF   = 'h70
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         mode_sha1,
    input  logic         resume,
    input  logic         last_blk,
    input  logic         irq_clr,
    input  logic         wr_start,
    input  logic [15:0]  wr_addr,
    input  logic [6:0]   wr_len,
    input  logic         wr_valid,
    input  logic [31:0]  wr_data,
    input  logic [15:0]  rd_addr,
    output logic [31:0]  rd_data,
    output logic         busy,
    output logic         irq,
    output logic         err,
    output logic         core_start,
    output logic         core_sha1,
    output logic [511:0] core_block,
    output logic [159:0] core_state_in,
    input  logic         core_done,
    input  logic [159:0] core_state_out
);

    localparam int BLK_WORDS = BLK_BYTES / 4;
    localparam int CTX_BYTES = CTX_WORDS * 4;
    localparam int ST_BITS   = ST_WORDS * WORD_BITS;
    localparam int IW        = 5;
    localparam int FW        = $clog2(BLK_BYTES + 1);

    hbf_state_e         st_q, st_d;
    logic [FW-1:0]      fill_cnt;
    logic [ST_BITS-1:0] chain_q;
    logic [63:0]        count_q;
    logic [CTX_BYTES*8-1:0] win_q;
    logic [CTX_BYTES*8-1:0] ctx_flat;
    logic               sha1_q, last_q, en_q;
    logic               buf_we, ctx_we, reject;
    logic [IW-1:0]      word_idx;
    logic               en_rise, blk_full, done_ok;
    logic [ST_BITS-1:0] new_state;
    logic [63:0]        new_count;
    logic [15:0]        rd_off;

    hbf_wr_decode #(
        .BASE(BASE_ADDR), .BLK_BYTES(BLK_BYTES), .CTX_OFF(CTX_OFF),
        .CTX_BYTES(CTX_BYTES), .IW(IW), .FW(FW)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
        .wr_len(wr_len), .wr_valid(wr_valid),
        .buf_allow(st_q == ST_FILL),
        .ctx_allow(st_q == ST_OFF || st_q == ST_FILL),
        .fill_cnt(fill_cnt), .buf_we(buf_we), .ctx_we(ctx_we),
        .word_idx(word_idx), .reject(reject)
    );

    hbf_word_store #(.WORDS(BLK_WORDS), .IW(IW)) u_blk (
        .clk(clk), .rst_n(rst_n), .we(buf_we), .idx(word_idx),
        .data(wr_data), .flat(core_block)
    );

    hbf_word_store #(.WORDS(CTX_WORDS), .IW(IW)) u_ctx (
        .clk(clk), .rst_n(rst_n), .we(ctx_we), .idx(word_idx),
        .data(wr_data), .flat(ctx_flat)
    );

    always_comb begin
        en_rise   = enable && !en_q;
        blk_full  = buf_we && (fill_cnt == FW'(BLK_BYTES - 4));
        done_ok   = (st_q == ST_WAIT) && core_done;
        new_state = hbf_mask(sha1_q, core_state_out);
        new_count = count_q + 64'(BLK_BYTES);
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:    if (en_rise) st_d = ST_FILL;
            ST_FILL: begin
                if (!enable)       st_d = ST_OFF;
                else if (blk_full) st_d = ST_LAUNCH;
            end
            ST_LAUNCH: st_d = ST_WAIT;
            ST_WAIT:   if (core_done) st_d = ST_FILL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_cnt <= '0;
            chain_q  <= '0;
            count_q  <= '0;
            win_q    <= '0;
            sha1_q   <= 1'b0;
            last_q   <= 1'b0;
            en_q     <= 1'b0;
            irq      <= 1'b0;
            err      <= 1'b0;
        end else begin
            en_q <= enable;
            if (st_q == ST_OFF && en_rise) begin
                sha1_q   <= mode_sha1;
                chain_q  <= resume ? hbf_mask(mode_sha1, ctx_flat[ST_BITS-1:0])
                                   : hbf_iv(mode_sha1);
                count_q  <= resume ? ctx_flat[CTX_BYTES*8-1:ST_BITS] : 64'd0;
                fill_cnt <= '0;
                err      <= 1'b0;
            end else if (reject) begin
                err <= 1'b1;
            end
            if (buf_we)            fill_cnt <= fill_cnt + FW'(4);
            if (st_q == ST_LAUNCH) fill_cnt <= '0;
            if (blk_full)          last_q   <= last_blk;
            if (done_ok) begin
                chain_q <= new_state;
                count_q <= new_count;
                win_q   <= {last_q ? 64'd0 : new_count, new_state};
                irq     <= 1'b1;
            end else if (irq_clr) begin
                irq <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        busy          = (st_q == ST_LAUNCH) || (st_q == ST_WAIT);
        core_start    = (st_q == ST_LAUNCH);
        core_sha1     = sha1_q;
        core_state_in = chain_q;
        rd_off        = rd_addr - BASE_ADDR - 16'(OUT_OFF);
        rd_data       = 32'h0;
        if (rd_off < 16'(CTX_BYTES) && rd_off[1:0] == 2'b00)
            rd_data = win_q[rd_off[4:2]*32 +: 32];
    end

endmodule

// File: rtl/hbf_checker.sv
module hbf_checker #(
    parameter int BLK_BYTES = 64,
    parameter int FW        = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          irq,
    input logic          irq_clr,
    input logic          core_start,
    input logic          core_done,
    input logic [FW-1:0] fill_cnt
);

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start); // R4

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= FW'(BLK_BYTES)); // R4

    AST_START_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> busy); // R9

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> busy); // R9

    AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !core_start && core_done) |=> irq); // R6

    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !(busy && !core_start && core_done)) |=> !irq); // R6

endmodule

bind hash_block_front hbf_checker #(.BLK_BYTES(BLK_BYTES), .FW(FW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .irq_clr(irq_clr),
    .core_start(core_start), .core_done(core_done), .fill_cnt(fill_cnt)
);

// File: tb/hash_block_front_test.sv
module hash_block_front_test;

    localparam logic [15:0] BASE = 16'h7A00;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 0, mode_sha1 = 0, resume = 0, last_blk = 0, irq_clr = 0;
    logic         wr_start = 0, wr_valid = 0;
    logic [15:0]  wr_addr = '0, rd_addr = '0;
    logic [6:0]   wr_len = '0;
    logic [31:0]  wr_data = '0;
    logic [31:0]  rd_data;
    logic         busy, irq, err, core_start, core_sha1, core_done;
    logic [511:0] core_block;
    logic [159:0] core_state_in, core_state_out;

    int checks = 0;
    int fails  = 0;
    logic [511:0] exp_blk;
    logic [159:0] exp_st;
    logic [63:0]  exp_cnt;
    logic         exp_sha1;
    int           core_cnt = 0;

    always #4 clk = ~clk;

    hash_block_front uut (.*);

    function automatic logic [159:0] core_fn(input logic [159:0] s, input logic [511:0] b);
        return s ^ b[159:0] ^ {5{32'h5A5A_A5A5}};
    endfunction

    function automatic logic [159:0] md5_mask(input logic sha1, input logic [159:0] s);
        logic [159:0] v = s;
        if (!sha1) v[159:128] = '0;
        return v;
    endfunction

    function automatic logic [511:0] place(input logic [511:0] v, input int off,
                                           input int len, input logic [7:0] seed);
        logic [511:0] r = v;
        for (int j = 0; j < len; j++) r[(off+j)*8 +: 8] = seed + 8'(j);
        return r;
    endfunction

    // compression core model
    always @(posedge clk) begin
        if (core_start) begin
            core_cnt       <= 6;
            core_state_out <= core_fn(core_state_in, core_block);
        end else if (core_cnt != 0) begin
            core_cnt <= core_cnt - 1;
        end
    end
    assign core_done = (core_cnt == 1);

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // one transaction; returns at the negedge after the last word
    task automatic xfer(input logic [15:0] addr, input int len, input logic [7:0] seed);
        @(negedge clk);
        wr_start = 1; wr_addr = addr; wr_len = 7'(len);
        @(negedge clk);
        wr_start = 0;
        for (int w = 0; w < (len + 3) / 4; w++) begin
            wr_valid = 1;
            for (int b = 0; b < 4; b++) wr_data[b*8 +: 8] = seed + 8'(w*4 + b);
            @(negedge clk);
        end
        wr_valid = 0;
    endtask

    task automatic read_win(output logic [223:0] w);
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            rd_addr = BASE + 16'h70 + 16'(4*k);
            #1 w[k*32 +: 32] = rd_data;
        end
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 50 && !irq; i++) @(negedge clk);
    endtask

    task automatic start_hash(input logic sha1, input logic res);
        @(negedge clk) enable = 0;
        @(negedge clk) begin mode_sha1 = sha1; resume = res; enable = 1; end
        @(negedge clk);
        exp_sha1 = sha1;
    endtask

    task automatic finish_block(input string tag);
        logic [223:0] w;
        wait_irq();
        chk({tag, " R6 irq"}, 256'(irq), 256'(1));
        exp_st  = md5_mask(exp_sha1, core_fn(exp_st, exp_blk));
        exp_cnt = exp_cnt + 64;
        read_win(w);
        chk({tag, " R7 window"}, 256'(w), 256'({last_blk ? 64'd0 : exp_cnt, exp_st}));
        @(negedge clk) irq_clr = 1;
        @(negedge clk) irq_clr = 0;
        chk({tag, " R6 irq cleared"}, 256'(irq), 256'(0));
    endtask

    task automatic t_reset();
        logic [223:0] w;
        chk("R1 busy", 256'(busy), 256'(0));
        chk("R1 irq", 256'(irq), 256'(0));
        chk("R1 err", 256'(err), 256'(0));
        chk("R1 core_start", 256'(core_start), 256'(0));
        read_win(w);
        chk("R1 window", 256'(w), 256'(0));
    endtask

    task automatic t_sha1_first();
        start_hash(1, 0);
        exp_st  = {32'hC3D2_E1F0, 32'h1032_5476, 32'h98BA_DCFE, 32'hEFCD_AB89, 32'h6745_2301};
        exp_cnt = 0;
        xfer(BASE, 16, 8'h10);
        chk("R4 no early start", 256'(core_start), 256'(0));
        xfer(BASE + 16, 48, 8'h40);
        exp_blk = place('0, 0, 16, 8'h10);
        exp_blk = place(exp_blk, 16, 48, 8'h40);
        chk("R4 start", 256'(core_start), 256'(1));
        chk("R2 sha1 iv", 256'(core_state_in), 256'(exp_st));
        chk("R5 block", core_block[255:0], exp_blk[255:0]);
        chk("R5 block hi", core_block[511:256], exp_blk[511:256]);
        chk("R11 sha1 sel", 256'(core_sha1), 256'(1));
        @(negedge clk);
        chk("R4 pulse ends", 256'(core_start), 256'(0));
        chk("R9 busy", 256'(busy), 256'(1));
        finish_block("sha1 first");
    endtask

    task automatic t_chain_last();
        last_blk = 1;
        for (int i = 15; i >= 0; i--) begin
            xfer(BASE + 16'(4*i), 4, 8'(8'h80 + 4*i));
            exp_blk = place(exp_blk, 4*i, 4, 8'(8'h80 + 4*i));
            if (i != 0) chk("R4 no start mid", 256'(core_start), 256'(0));
        end
        chk("R4 start after words", 256'(core_start), 256'(1));
        chk("R10 chained state", 256'(core_state_in), 256'(exp_st));
        chk("R5 reversed placement", core_block[255:0], exp_blk[255:0]);
        finish_block("chain last");
        last_blk = 0;
    endtask

    task automatic t_errors();
        start_hash(1, 0);
        exp_st  = {32'hC3D2_E1F0, 32'h1032_5476, 32'h98BA_DCFE, 32'hEFCD_AB89, 32'h6745_2301};
        exp_cnt = 0;
        xfer(BASE, 6, 8'h00);
        chk("R8 bad length err", 256'(err), 256'(1));
        start_hash(1, 0);
        chk("R8 err cleared at enable", 256'(err), 256'(0));
        xfer(BASE + 2, 4, 8'h00);
        chk("R8 misaligned err", 256'(err), 256'(1));
        xfer(BASE, 60, 8'h20);
        exp_blk = place(exp_blk, 0, 60, 8'h20);
        xfer(BASE + 60, 8, 8'hE0);
        chk("R8 overflow no start", 256'(core_start), 256'(0));
        xfer(BASE + 60, 4, 8'hC0);
        exp_blk = place(exp_blk, 60, 4, 8'hC0);
        chk("R8 start at 64", 256'(core_start), 256'(1));
        chk("R8 block", core_block[511:256], exp_blk[511:256]);
        finish_block("errors");

        start_hash(1, 0);
        exp_st  = {32'hC3D2_E1F0, 32'h1032_5476, 32'h98BA_DCFE, 32'hEFCD_AB89, 32'h6745_2301};
        exp_cnt = 0;
        xfer(BASE, 64, 8'h33);
        exp_blk = place(exp_blk, 0, 64, 8'h33);
        chk("R9 start", 256'(core_start), 256'(1));
        xfer(BASE, 4, 8'hF0);
        chk("R9 busy write err", 256'(err), 256'(1));
        chk("R9 buffer untouched", core_block[255:0], exp_blk[255:0]);
        finish_block("busy write");
        xfer(BASE, 64, 8'h55);
        exp_blk = place(exp_blk, 0, 64, 8'h55);
        chk("R9 total not advanced", 256'(core_start), 256'(1));
        finish_block("after busy");
    endtask

    task automatic t_resume_md5();
        logic [511:0] c;
        @(negedge clk) enable = 0;
        xfer(BASE + 16'h40, 28, 8'h70);
        c = place('0, 0, 28, 8'h70);
        start_hash(0, 1);
        exp_st  = md5_mask(0, c[159:0]);
        exp_cnt = c[223:160];
        xfer(BASE, 64, 8'h09);
        exp_blk = place(exp_blk, 0, 64, 8'h09);
        chk("R3 resumed state", 256'(core_state_in), 256'(exp_st));
        chk("R11 md5 sel", 256'(core_sha1), 256'(0));
        finish_block("resume md5 R3");
        start_hash(0, 0);
        chk("R2 md5 iv", 256'(core_state_in),
            256'({32'h0, 32'h1032_5476, 32'h98BA_DCFE, 32'hEFCD_AB89, 32'h6745_2301}));
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        exp_blk = '0; exp_st = '0; exp_cnt = '0; exp_sha1 = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_sha1_first();
        t_chain_last();
        t_errors();
        t_resume_md5();
        finish_up();
    end

endmodule